// File: doc/BRIEF.md
# Pin I/O Controller with Interrupt Triggers

This block is a register-mapped general-purpose pin controller for up to 32 pins. Software picks, pin by pin, whether the pin is driven or sampled, sets the level driven on output pins, and reads back the level of every pin. Each pin also feeds an interrupt detector that can react to a high level, a low level, a rising edge, a falling edge or any transition. Detected events are held in a per-pin latch until software acknowledges them. An enable mask decides which latched events reach the single interrupt output.

The register port is a single-cycle 32-bit port. A write takes effect on the clock edge where the write strobe is high. Reads are combinational from the byte address. Incoming pins pass through a two-stage synchronizer before any detection. The any-transition trigger exists only when the feature level parameter is 3 or above. Below that, the select register for it reads zero and has no effect.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Registers sit at these byte offsets: 0x00 pin level, 0x04 input select, 0x08 interrupt mask, 0x0C raw events, 0x10 masked events, 0x14 event acknowledge, 0x18 trigger kind, 0x1C trigger polarity, 0x20 feature level, 0x24 any-transition select. After reset the input select is all ones, every other writable register is zero, irq is low, and the feature level reads the VERSION parameter.
- R2: An input-select bit of 1 makes the pin an input and 0 makes it an output: pin_oe is the inverse of the input select, and pin_out carries the last value written to the pin level register.
- R3: Reading the pin level register returns the synchronized pin_in bit for input pins and the driven bit for output pins.
- R4: With trigger kind 0 (level), polarity 1 latches an event while the pin is high and polarity 0 while it is low. The event bit is 0 on the cycle right after an acknowledge and sets again on the next cycle while the level persists.
- R5: With trigger kind 1 (edge) and any-transition 0, polarity 1 latches an event on a 0-to-1 change and polarity 0 on a 1-to-0 change. No event follows the other direction.
- R6: With trigger kind 1 and any-transition 1, both directions latch an event whatever the polarity. This holds only if VERSION is 3 or more. Otherwise the any-transition register reads zero, and the pin follows its polarity.
- R7: Writing the acknowledge register clears each latched event whose data bit is 1. An acknowledge wins over a new event in the same cycle. Zero bits leave their events latched.
- R8: The raw event register reads the latched events regardless of the mask. The masked event register reads the latched events ANDed with the mask.
- R9: irq is a registered OR of all masked events. A zero mask keeps irq low without losing latched events, and re-enabling the mask raises irq.
- R10: Register bits at and above NUM_PINS read zero. Unmapped or misaligned addresses and the acknowledge register read zero.
- R11: A pin change applied between clock edges shows in the raw event register after the third rising edge and on irq after the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | NUM_PINS | Levels sampled from the pins |
| pin_out | output | NUM_PINS | Levels driven onto output pins |
| pin_oe | output | NUM_PINS | Output enable per pin, 1 drives |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted latch bit shows at once in a read of the raw or masked event register, and on irq one edge later. A wrong trigger decode shows as a missing or extra event three edges after the pin moves. The sweeps set each trigger mode, move each pin through both directions, and step the mask through many patterns. After every change they read back the raw and masked events and the irq level, so any stray state reaches the ports within a few cycles of the stimulus. A second instance at a lower feature level shows whether the any-transition select is truly absent there.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int REG_W = 32;
  localparam int MIN_ANY_VERSION = 3;

  // register word index; byte offset is index * 4
  typedef enum logic [3:0] {
    RI_LEVEL  = 4'd0,
    RI_INSEL  = 4'd1,
    RI_MASK   = 4'd2,
    RI_RAW    = 4'd3,
    RI_MASKED = 4'd4,
    RI_ACK    = 4'd5,
    RI_KIND   = 4'd6,
    RI_POL    = 4'd7,
    RI_FEAT   = 4'd8,
    RI_ANY    = 4'd9
  } reg_idx_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] dout_d
);

  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] stage_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < DEPTH; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout   = stage_q[STAGES-1];
  assign dout_d = stage_q[STAGES];

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] kind_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] any_i,
  output logic [W-1:0] evt_o
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, lvl_hit, edg_hit;

    assign rise    = cur_i[i] & ~prev_i[i];
    assign fall    = ~cur_i[i] & prev_i[i];
    assign lvl_hit = pol_i[i] ? cur_i[i] : ~cur_i[i];
    assign edg_hit = any_i[i] ? (rise | fall) : (pol_i[i] ? rise : fall);
    assign evt_o[i] = kind_i[i] ? edg_hit : lvl_hit;

    // R5
    single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o[i] && kind_i[i] && !any_i[i]) |=>
      !(evt_o[i] && $stable(kind_i[i]) && $stable(pol_i[i]) && !any_i[i]));
  end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 6,
  parameter int VERSION  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);

  localparam int NP = NUM_PINS;
  localparam bit HAS_ANY = (VERSION >= MIN_ANY_VERSION);

  localparam logic [ADDR_W-1:0] OFF_LEVEL  = ADDR_W'(4 * RI_LEVEL);
  localparam logic [ADDR_W-1:0] OFF_INSEL  = ADDR_W'(4 * RI_INSEL);
  localparam logic [ADDR_W-1:0] OFF_MASK   = ADDR_W'(4 * RI_MASK);
  localparam logic [ADDR_W-1:0] OFF_RAW    = ADDR_W'(4 * RI_RAW);
  localparam logic [ADDR_W-1:0] OFF_MASKED = ADDR_W'(4 * RI_MASKED);
  localparam logic [ADDR_W-1:0] OFF_ACK    = ADDR_W'(4 * RI_ACK);
  localparam logic [ADDR_W-1:0] OFF_KIND   = ADDR_W'(4 * RI_KIND);
  localparam logic [ADDR_W-1:0] OFF_POL    = ADDR_W'(4 * RI_POL);
  localparam logic [ADDR_W-1:0] OFF_FEAT   = ADDR_W'(4 * RI_FEAT);
  localparam logic [ADDR_W-1:0] OFF_ANY    = ADDR_W'(4 * RI_ANY);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // write decode
  logic [NP-1:0] wr_pins;
  logic hit_level, hit_insel, hit_mask, hit_ack, hit_kind, hit_pol, hit_any;

  assign wr_pins   = bus_wdata[NP-1:0];
  assign hit_level = bus_we && (bus_addr == OFF_LEVEL);
  assign hit_insel = bus_we && (bus_addr == OFF_INSEL);
  assign hit_mask  = bus_we && (bus_addr == OFF_MASK);
  assign hit_ack   = bus_we && (bus_addr == OFF_ACK);
  assign hit_kind  = bus_we && (bus_addr == OFF_KIND);
  assign hit_pol   = bus_we && (bus_addr == OFF_POL);
  assign hit_any   = bus_we && (bus_addr == OFF_ANY);

  if (NP < REG_W) begin : g_wide_bus
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata[REG_W-1:NP];
  end

  // configuration registers
  logic [NP-1:0] level_q, insel_q, mask_q, kind_q, pol_q, any_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      level_q <= '0;
      insel_q <= '1;
      mask_q  <= '0;
      kind_q  <= '0;
      pol_q   <= '0;
    end else begin
      if (hit_level) level_q <= wr_pins;
      if (hit_insel) insel_q <= wr_pins;
      if (hit_mask)  mask_q  <= wr_pins;
      if (hit_kind)  kind_q  <= wr_pins;
      if (hit_pol)   pol_q   <= wr_pins;
    end
  end

  if (HAS_ANY) begin : g_any
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)  any_q <= '0;
      else if (hit_any) any_q <= wr_pins;
    end
  end else begin : g_no_any
    logic unused_hit_any;
    assign unused_hit_any = hit_any;
    assign any_q = '0;
  end

  // pin sampling and trigger detection
  logic [NP-1:0] pin_now, pin_prev, evt;

  gpio_in_sync #(.W(NP), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .din    (pin_in),
    .dout   (pin_now),
    .dout_d (pin_prev)
  );

  gpio_trig_detect #(.W(NP)) u_detect (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cur_i  (pin_now),
    .prev_i (pin_prev),
    .kind_i (kind_q),
    .pol_i  (pol_q),
    .any_i  (any_q),
    .evt_o  (evt)
  );

  // event latch and interrupt, next state
  logic [NP-1:0] latch_q, latch_d, ack_pins;
  logic          irq_q, irq_d;

  always_comb begin
    ack_pins = hit_ack ? wr_pins : '0;
    latch_d  = (latch_q | evt) & ~ack_pins;
    irq_d    = |(latch_q & mask_q);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      latch_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      latch_q <= latch_d;
      irq_q   <= irq_d;
    end
  end

  assign irq     = irq_q;
  assign pin_out = level_q;
  assign pin_oe  = ~insel_q;

  // read path
  logic [NP-1:0] rd_pins;
  logic          rd_feat;

  always_comb begin
    rd_pins = '0;
    rd_feat = 1'b0;
    case (bus_addr)
      OFF_LEVEL:  rd_pins = (insel_q & pin_now) | (~insel_q & level_q);
      OFF_INSEL:  rd_pins = insel_q;
      OFF_MASK:   rd_pins = mask_q;
      OFF_RAW:    rd_pins = latch_q;
      OFF_MASKED: rd_pins = latch_q & mask_q;
      OFF_KIND:   rd_pins = kind_q;
      OFF_POL:    rd_pins = pol_q;
      OFF_ANY:    rd_pins = any_q;
      OFF_FEAT:   rd_feat = 1'b1;
      default:    rd_pins = '0;
    endcase
    bus_rdata = rd_feat ? REG_W'(VERSION) : REG_W'(rd_pins);
  end

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit_ack |=> ((latch_q & $past(wr_pins)) == '0));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !hit_ack |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

  // R9
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mask_q == '0) |=> !irq);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq) |-> $past((latch_q & mask_q) != '0));

endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb_top;

  localparam int NP = 8;
  localparam logic [5:0] O_LEVEL = 6'h00, O_INSEL = 6'h04, O_MASK = 6'h08,
                         O_RAW = 6'h0C, O_MASKED = 6'h10, O_ACK = 6'h14,
                         O_KIND = 6'h18, O_POL = 6'h1C, O_FEAT = 6'h20,
                         O_ANY = 6'h24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [5:0]    addr;
  logic          we;
  logic [31:0]   wdata;
  logic [31:0]   rdata, rdata_old;
  logic [NP-1:0] drv, pout, poe, pout_old, poe_old;
  logic          irq, irq_old;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(NP), .ADDR_W(6), .VERSION(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .pin_in(drv), .pin_out(pout), .pin_oe(poe), .irq(irq));

  gpio_irq_ctrl #(.NUM_PINS(NP), .ADDR_W(6), .VERSION(2)) dut_old_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata_old), .pin_in(drv), .pin_out(pout_old), .pin_oe(poe_old),
    .irq(irq_old));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d, output logic [31:0] dold);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
    dold = rdata_old;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r, ro;
    rst_n = 1'b0; addr = '0; we = 1'b0; wdata = '0; drv = '0;
    idle(3);
    rst_n = 1'b1;
    idle(5);

    // R1 reset state; pins low with level-low default trigger latch raw events
    rd(O_INSEL, r, ro);  chk("R1 insel", r, 32'hFF);
    rd(O_MASK, r, ro);   chk("R1 mask", r, 32'h0);
    rd(O_KIND, r, ro);   chk("R1 kind", r, 32'h0);
    rd(O_POL, r, ro);    chk("R1 pol", r, 32'h0);
    rd(O_ANY, r, ro);    chk("R1 any", r, 32'h0);
    rd(O_FEAT, r, ro);   chk("R1 feat", r, 32'd3); chk("R1 feat old", ro, 32'd2);
    rd(O_RAW, r, ro);    chk("R1 R4 raw", r, 32'hFF);
    rd(O_MASKED, r, ro); chk("R1 R8 masked", r, 32'h0);
    chk("R1 oe", {24'h0, poe}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R10 upper bits, unmapped, misaligned, acknowledge
    wr(O_INSEL, 32'hFFFF_FFFF);
    rd(O_INSEL, r, ro);  chk("R10 upper", r, 32'hFF);
    rd(6'h28, r, ro);    chk("R10 unmapped", r, 32'h0);
    rd(6'h06, r, ro);    chk("R10 misaligned", r, 32'h0);
    rd(O_ACK, r, ro);    chk("R10 ack", r, 32'h0);

    // R2 R3 direction and level
    wr(O_INSEL, 32'h0F);
    wr(O_LEVEL, 32'hA5);
    drv = 8'h3C;
    idle(4);
    chk("R2 oe", {24'h0, poe}, 32'hF0);
    chk("R2 out", {24'h0, pout}, 32'hA5);
    rd(O_LEVEL, r, ro); chk("R3 level read", r, 32'hAC);
    wr(O_INSEL, 32'hFF);
    rd(O_LEVEL, r, ro); chk("R3 all inputs", r, 32'h3C);

    // R4 R8 R9 level sweep over all pin patterns, both polarities
    wr(O_KIND, 32'h0);
    for (int pol = 0; pol < 2; pol++) begin
      wr(O_POL, pol ? 32'hFF : 32'h0);
      for (int v = 0; v < 256; v++) begin
        logic [7:0] m, e;
        m = 8'((v * 37 + 11) & 255);
        e = pol ? 8'(v) : ~8'(v);
        drv = 8'(v);
        wr(O_MASK, {24'h0, m});
        idle(4);
        wr(O_ACK, 32'hFF);
        if (v == 85) begin
          addr = O_RAW; #1;
          chk("R4 cleared after ack", rdata, 32'h0);
        end
        idle(3);
        rd(O_RAW, r, ro);    chk("R4 level raw", r, {24'h0, e});
        chk("R4 level raw old", ro, {24'h0, e});
        rd(O_MASKED, r, ro); chk("R8 masked", r, {24'h0, e & m});
        chk("R9 irq", {31'h0, irq}, {31'h0, |(e & m)});
      end
    end

    // R5 R6 edge sweep: mode 0 rising, 1 falling, 2 any transition
    wr(O_KIND, 32'hFF);
    wr(O_MASK, 32'hFF);
    for (int mode = 0; mode < 3; mode++) begin
      wr(O_POL, (mode != 1) ? 32'hFF : 32'h0);
      wr(O_ANY, (mode == 2) ? 32'hFF : 32'h0);
      for (int p = 0; p < NP; p++) begin
        logic [7:0] b;
        b = 8'(1 << p);
        drv = '0;
        idle(4);
        wr(O_ACK, 32'hFF);
        idle(1);
        drv = b;
        idle(4);
        rd(O_RAW, r, ro);
        chk("R5 R6 up", r, (mode != 1) ? {24'h0, b} : 32'h0);
        chk("R6 up old", ro, (mode != 1) ? {24'h0, b} : 32'h0);
        wr(O_ACK, 32'hFF);
        idle(1);
        drv = '0;
        idle(4);
        rd(O_RAW, r, ro);
        chk("R5 R6 down", r, (mode != 0) ? {24'h0, b} : 32'h0);
        chk("R6 down old", ro, (mode == 1) ? {24'h0, b} : 32'h0);
      end
      rd(O_ANY, r, ro);
      chk("R6 any reg", r, (mode == 2) ? 32'hFF : 32'h0);
      chk("R6 any reg old", ro, 32'h0);
    end

    // R7 partial acknowledge, zero bits
    wr(O_POL, 32'hFF);
    wr(O_ANY, 32'h0);
    drv = '0; idle(4);
    wr(O_ACK, 32'hFF);
    drv = 8'hFF; idle(4);
    wr(O_ACK, 32'h0F);
    rd(O_RAW, r, ro); chk("R7 partial", r, 32'hF0);
    wr(O_ACK, 32'h0);
    rd(O_RAW, r, ro); chk("R7 zero bits", r, 32'hF0);

    // R9 mask suppression keeps events
    wr(O_MASK, 32'h0);
    idle(2);
    chk("R9 suppressed", {31'h0, irq}, 32'h0);
    rd(O_RAW, r, ro); chk("R9 kept", r, 32'hF0);
    wr(O_MASK, 32'h30);
    idle(2);
    chk("R9 re-enabled", {31'h0, irq}, 32'h1);
    rd(O_MASKED, r, ro); chk("R8 masked subset", r, 32'h30);

    // R11 latency from pin change
    wr(O_MASK, 32'hFF);
    drv = '0; idle(4);
    wr(O_ACK, 32'hFF);
    idle(2);
    chk("R11 idle irq", {31'h0, irq}, 32'h0);
    drv = 8'h01;
    @(negedge clk);
    @(negedge clk);
    addr = O_RAW; #1;
    chk("R11 after two edges", rdata, 32'h0);
    @(negedge clk); #1;
    chk("R11 after three edges", rdata, 32'h1);
    chk("R11 irq not yet", {31'h0, irq}, 32'h0);
    @(negedge clk); #1;
    chk("R11 irq after four edges", {31'h0, irq}, 32'h1);

    finish_run();
  end

endmodule